// File: doc/BRIEF.md
# Four-Phase Dithered Pulse-Width Modulator

This block turns a 13-bit duty command into four interleaved pulse-width modulated gate signals for a multi-phase buck converter. A single 10-bit counter runs on a fast clock that ticks 1024 times per switching period, so one period is 1024 ticks. The upper five counter bits act as a coarse segment index with 32 segments per period. The lower five bits act as a fine position with 32 positions per segment. Each output is set at the start of its own period. It is cleared when the coarse and fine fields of its local count both equal the effective duty. Both comparisons are registered before they reach the output flop.

The four phases share the counter. Each phase adds a fixed offset of a quarter period (0, 256, 512 and 768 ticks), so all four outputs have the same pulse width in the same period. The three low command bits are a fraction. A 3-bit accumulator adds the fraction once per period, and a period gets one extra tick whenever that addition carries out. Across any eight periods this gives the fraction in eighths of a tick on average, with the longer periods spread out.

Top module: `dither_dpwm4`

## Requirements
- R1: Under the active-low asynchronous reset all four outputs are low, the counter is zero, the dither accumulator is zero and the held duty is zero. Outputs therefore stay low for the whole first counter period after reset, whatever command is applied.
- R2: Number the clock edges after reset release from 1. Phase p (p = 0..3) starts a period right after each edge n with n ≡ 2 − 256·p (mod 1024). Its output is high from that edge exactly when its width is nonzero, and it never rises after any other edge.
- R3: In each of its periods, an output stays high for exactly W consecutive clocks, where W is the effective 10-bit width held for that period. When W = 0 it stays low for the whole period.
- R4: The command is split into duty_cmd[12:3], the integer width (bits 12:8 select the coarse segment, bits 7:3 the fine position), and duty_cmd[2:0], the fraction. The command is sampled only on edges numbered as multiples of 1024. A change between those edges does not alter the period in progress.
- R5: On each sampling edge, the fraction is added into the 3-bit accumulator. The next period's width is the integer part plus one if that addition carries out, and the integer part otherwise. With a constant command, any eight consecutive periods sum to 8·integer + fraction, and their widths differ by at most one.
- R6: An integer part of 1023 with a carry stays at width 1023. Every output is low for at least the last clock of each of its periods.
- R7: Phases 1 to 3 use the width computed at the most recent sampling edge. Phase 0 uses the width computed at the edge that starts its period. So every phase has the same width within one counter period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock, 1024 ticks per switching period |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | 13 | Duty command: integer width [12:3], dither fraction [2:0] |
| pwm_out | output | 4 | Gate drive outputs, bit p is phase p |

## Verification
A wrong counter or offset shows up at the very next period start as an output that rises in the wrong slot. It is seen within one period of 1024 clocks. A stale or mis-rounded held width shows up as a wrong pulse length at the next period boundary of each phase. A broken dither accumulator only shows once eight periods are summed and compared against the command, or when widths jump by more than one tick inside such a window. A command latched at the wrong moment is caught by changing the command mid-period and checking that the pulse in progress keeps its old length.

// File: rtl/dither_dpwm4.sv
module dither_dpwm4 #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 5,
  parameter int DITHER_W = 3,
  parameter int PHASES   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [COARSE_W+FINE_W+DITHER_W-1:0]   duty_cmd,
  output logic [PHASES-1:0]                     pwm_out
);
  localparam int CNT_W  = COARSE_W + FINE_W;
  localparam int CMD_W  = CNT_W + DITHER_W;
  localparam int PERIOD = 1 << CNT_W;
  localparam int SPAN   = PERIOD / PHASES;

  logic [CNT_W-1:0]    cnt, base, base_next, cur_base, whole;
  logic [DITHER_W-1:0] acc;
  logic [DITHER_W:0]   acc_sum;
  logic                wrap, carry;

  assign wrap      = &cnt;
  assign whole     = duty_cmd[CMD_W-1:DITHER_W];
  assign acc_sum   = {1'b0, acc} + {1'b0, duty_cmd[DITHER_W-1:0]};
  assign carry     = acc_sum[DITHER_W];
  assign base_next = (carry && !(&whole)) ? whole + CNT_W'(1) : whole;
  assign cur_base  = wrap ? base_next : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      acc  <= '0;
      base <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
      if (wrap) begin
        acc  <= acc_sum[DITHER_W-1:0];
        base <= base_next;
      end
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    localparam logic [CNT_W-1:0] OFF = CNT_W'(p * SPAN);
    logic [CNT_W-1:0] lc, eff;
    logic             hit_set, hit_coarse, hit_fine, level;

    assign lc = cnt + OFF;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        eff        <= '0;
        hit_set    <= 1'b0;
        hit_coarse <= 1'b0;
        hit_fine   <= 1'b0;
        level      <= 1'b0;
      end else begin
        if (&lc) eff <= cur_base;
        hit_set    <= (lc == '0) && (eff != '0);
        hit_coarse <= lc[CNT_W-1:FINE_W] == eff[CNT_W-1:FINE_W];
        hit_fine   <= lc[FINE_W-1:0] == eff[FINE_W-1:0];
        if (hit_set)                    level <= 1'b1;
        else if (hit_coarse && hit_fine) level <= 1'b0;
      end
    end

    assign pwm_out[p] = level;
  end
endmodule

// File: rtl/dither_dpwm4_chk.sv
module dither_dpwm4_chk #(
  parameter int CNT_W    = 10,
  parameter int DITHER_W = 3,
  parameter int PHASES   = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CNT_W-1:0]          cnt,
  input logic [CNT_W-1:0]          base,
  input logic [CNT_W+DITHER_W-1:0] duty_cmd,
  input logic [PHASES-1:0]         pwm_out
);
  localparam int SPAN = (1 << CNT_W) / PHASES;

  a_r4_base_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $stable(base));

  a_r5_base_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && $past(rst_n)) |->
      (base == $past(duty_cmd[CNT_W+DITHER_W-1:DITHER_W]) ||
       {1'b0, base} == {1'b0, $past(duty_cmd[CNT_W+DITHER_W-1:DITHER_W])} + (CNT_W+1)'(1)));

  for (genvar p = 0; p < PHASES; p++) begin : g_chk
    logic [CNT_W-1:0] lc;
    assign lc = cnt + CNT_W'(p * SPAN);

    a_r2_rise_slot: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[p]) |-> (lc == CNT_W'(2)));

    a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (lc == CNT_W'(1)) |-> !pwm_out[p]);
  end
endmodule

bind dither_dpwm4 dither_dpwm4_chk #(
  .CNT_W(CNT_W), .DITHER_W(DITHER_W), .PHASES(PHASES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .base(base),
  .duty_cmd(duty_cmd), .pwm_out(pwm_out)
);

// File: tb/dither_dpwm4_bench.sv
module dither_dpwm4_bench;
  localparam int PERIOD = 1024;
  localparam int SPAN   = 256;
  localparam int NVEC   = 10;

  localparam logic [12:0] VEC_DUTY [NVEC] = '{
    13'd0, 13'd8, 13'd1, 13'd804, 13'd4143,
    13'd8003, 13'd8184, 13'd8191, 13'd253, 13'd258};
  localparam int VEC_SUM [NVEC] = '{
    0, 8, 1, 804, 4143, 8003, 8184, 8184, 253, 258};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] duty = '0;
  logic [3:0]  pwm;

  always #10 clk = ~clk;

  dither_dpwm4 u_dither_dpwm4 (.clk(clk), .rst_n(rst_n), .duty_cmd(duty), .pwm_out(pwm));

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int k = 0, m_acc = 0, m_base = 0, m_hi = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      k = 0; m_acc = 0; m_base = 0;
    end else begin
      k = k + 1;
      if (k % PERIOD == 0) begin
        m_hi  = int'(duty[12:3]);
        m_acc = m_acc + int'(duty[2:0]);
        if (m_acc >= 8) begin
          m_acc  = m_acc - 8;
          m_base = (m_hi == 1023) ? 1023 : m_hi + 1;
        end else m_base = m_hi;
      end
    end
  end

  int hc [4];
  int expw [4];
  bit prv [4];
  int len0 [16];
  int done0 = 0;

  always @(negedge clk) begin
    for (int p = 0; p < 4; p++) begin
      bit st;
      st = ((k + p*SPAN + PERIOD - 2) % PERIOD) == 0;
      if (!rst_n) begin
        check(pwm[p] == 1'b0, "R1 output low in reset", int'(pwm[p]), 0);
        hc[p] = 0; expw[p] = 0; prv[p] = 1'b0;
      end else begin
        if (st) begin
          check(hc[p] == expw[p], $sformatf("R3/R5/R7 width phase %0d", p), hc[p], expw[p]);
          check(pwm[p] == (m_base != 0), $sformatf("R2 start level phase %0d", p),
                int'(pwm[p]), int'(m_base != 0));
          if (p == 0) begin
            len0[done0 % 16] = hc[0];
            done0++;
          end
          expw[p] = m_base;
          hc[p] = int'(pwm[p]);
        end else begin
          if (pwm[p] && !prv[p])
            check(1'b0, $sformatf("R2 rise outside slot phase %0d", p),
                  k % PERIOD, (PERIOD + 2 - p*SPAN) % PERIOD);
          hc[p] = hc[p] + int'(pwm[p]);
        end
        prv[p] = pwm[p];
      end
    end
  end

  task automatic wait_pos(input int pos);
    do @(negedge clk); while ((k % PERIOD) != pos);
    #1;
  endtask

  task automatic wait_done(input int target);
    while (done0 < target) @(posedge clk);
  endtask

  initial begin
    int d0, s, mn, mx;
    repeat (5) @(negedge clk);
    #1 rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++) begin
      wait_pos(1000);
      duty = VEC_DUTY[v];
      d0 = done0;
      wait_done(d0 + 9);
      s = 0; mn = 2000; mx = -1;
      for (int i = 1; i <= 8; i++) begin
        int l;
        l = len0[(d0 + i) % 16];
        s = s + l;
        if (l < mn) mn = l;
        if (l > mx) mx = l;
      end
      check(s == VEC_SUM[v], $sformatf("R5 eight-period sum vec %0d", v), s, VEC_SUM[v]);
      check(mx - mn <= 1, $sformatf("R5 spread vec %0d", v), mx - mn, 1);
      if (VEC_DUTY[v] == 13'd8191)
        check(mx == 1023, "R6 saturated width", mx, 1023);
    end

    wait_pos(1000);
    duty = {10'd200, 3'd0};
    d0 = done0;
    wait_done(d0 + 2);
    wait_pos(300);
    duty = {10'd600, 3'd0};
    d0 = done0;
    wait_done(d0 + 2);
    check(len0[d0 % 16] == 200, "R4 mid-period change ignored", len0[d0 % 16], 200);
    check(len0[(d0 + 1) % 16] == 600, "R4 change applied at boundary", len0[(d0 + 1) % 16], 600);

    wait_pos(500);
    rst_n = 1'b0;
    @(negedge clk);
    check(pwm == 4'b0000, "R1 async reset clears outputs", int'(pwm), 0);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    d0 = done0;
    wait_done(d0 + 3);
    check(len0[(d0 + 1) % 16] == 0, "R1 first period after reset", len0[(d0 + 1) % 16], 0);
    check(len0[(d0 + 2) % 16] == 600, "R4 command after reset", len0[(d0 + 2) % 16], 600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule